// File: doc/BRIEF.md
# SPI Register Front End for a Real-Time Clock

This block is the serial slave side of a real-time-clock register file. A master pulls chip select low, shifts in one command byte and then one or more data bytes. Bit 7 of the command byte chooses the direction: clear means read, set means write. The low four bits give the starting register. The pointer then steps through a sixteen-register window, one register per data byte, and wraps from the top of the window to the bottom.

Reads of the eight timekeeping registers come from a shadow copy. The block loads this copy from the live counter bus at the moment chip select goes low. A burst read therefore returns one consistent instant while the counters keep running. Writes to those registers go to the separate counting block through a one-cycle write strobe, and writes to the four hours-and-below registers also pulse a prescaler clear. Four alarm registers are held inside this block. The remaining addresses are empty.

The SPI pins are synchronized into the system clock domain, so the system clock must run several times faster than the serial clock. Data moves MSB first. The input is taken on the rising serial-clock edge, and the output changes on the falling edge.

Top module: `spi_rtc_regif`

## Requirements
- R1: In the command byte, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits [3:0] give the starting register address.
- R2: Bits are MSB first. MOSI is taken on rising SCLK edges and MISO changes on falling SCLK edges. MISO is 0 while chip select is high and while the command byte is being received.
- R3: After each data byte the register pointer advances by one, wrapping from 0Fh to 00h.
- R4: On the falling edge of chip select, the eight live timekeeping bytes are copied into a shadow set. Every read of addresses 00h–07h in that access returns the shadow value, even if the live bus changes.
- R5: A write data byte takes effect only after all 8 bits have arrived. For addresses 00h–07h it produces exactly one cycle of cnt_wr_en, with cnt_wr_addr = address[2:0].
- R6: presc_clr pulses together with cnt_wr_en for writes to addresses 00h–03h only.
- R7: Each timekeeping register has a mask of implemented bits. Masked-off bits read as 0 and are sent as 0 on cnt_wr_data. The masks are: 00h FFh, 01h 7Fh, 02h 7Fh, 03h 7Fh, 04h 07h, 05h 3Fh, 06h 9Fh, 07h FFh.
- R8: Addresses 08h–0Bh are four 8-bit alarm registers kept in the block. They are written with full bytes and read back unchanged, and they cause no cnt_wr_en.
- R9: Addresses 0Ch–0Fh read as 00h. Writes to them cause no strobe and change no state.
- R10: Raising chip select in the middle of a byte discards the partial byte. The next access starts with a fresh command byte.
- R11: After reset, MISO is 0, there are no strobes, and the alarm registers read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| live_time | input | 64 | Live timekeeping bytes from the counter; register n on bits [8n+7:8n] |
| cnt_wr_en | output | 1 | One-cycle write strobe to the counter |
| cnt_wr_addr | output | 3 | Timekeeping register being written |
| cnt_wr_data | output | 8 | Masked write data |
| presc_clr | output | 1 | Clear pulse for the sub-hundredths prescaler |

## Verification
On every cycle the assertions check these properties:
- Write and prescaler-clear strobes last exactly one cycle, and a prescaler clear only appears with a strobe to an hours-or-below register.
- Write data never carries an unimplemented bit.
- The shadow stays frozen for the whole access.
- The pointer wraps at the window top.
- Raising chip select clears the bit counter and silences MISO.

Some behaviours only the bench's scenarios can show:
- Coherent burst reads while the live bus changes.
- Wrap-around across the empty addresses into the clock registers.
- Alarm read-back.
- Ignored writes to the empty addresses.
- Recovery after an aborted byte.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;
  localparam int BYTE_W = 8;

  // Implemented-bit mask of each timekeeping register (R7)
  function automatic logic [7:0] time_mask(input int idx);
    case (idx)
      1, 2, 3: return 8'h7F;
      4:       return 8'h07;
      5:       return 8'h3F;
      6:       return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic cmd_is_write(input logic [7:0] cmd);
    return cmd[7];
  endfunction
endpackage

// File: rtl/spi_rtc_sync.sv
module spi_rtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csn,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_fall,
  output logic mosi_s
);
  logic [STAGES:0]   sclk_p;
  logic [STAGES:0]   csn_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '1;
      csn_p  <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk};
      csn_p  <= {csn_p[STAGES-1:0], csn};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
    end
  end

  assign sclk_rise = ~sclk_p[STAGES] & sclk_p[STAGES-1];
  assign sclk_fall = sclk_p[STAGES] & ~sclk_p[STAGES-1];
  assign cs_act    = ~csn_p[STAGES-1];
  assign cs_fall   = csn_p[STAGES] & ~csn_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_rtc_shifter.sv
module spi_rtc_shifter
  import spi_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic              tx_vld,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sh[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      tx_sh   <= '0;
      rx_done <= 1'b0;
      miso    <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt <= '0;     // R10: partial byte dropped
      rx_sh   <= '0;
      tx_sh   <= '0;
      rx_done <= 1'b0;
      miso    <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (sclk_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          rx_done <= 1'b1;
          rx_byte <= rx_next;
        end
      end
      if (tx_vld) begin
        tx_sh <= tx_data;
      end else if (sclk_fall) begin
        miso  <= tx_sh[BYTE_W-1];
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0) && !rx_done);
  a_r2_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);
  a_r5_done_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(sclk_rise));
endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs
  import spi_rtc_pkg::*;
#(
  parameter int N_TIME  = 8,
  parameter int N_ALARM = 4,
  parameter int N_CLR   = 4,
  parameter int AW      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_act,
  input  logic                       cs_fall,
  input  logic                       rx_done,
  input  logic [BYTE_W-1:0]          rx_byte,
  input  logic [N_TIME*BYTE_W-1:0]   live_time,
  output logic                       tx_vld,
  output logic [BYTE_W-1:0]          tx_data,
  output logic                       wr_en,
  output logic [$clog2(N_TIME)-1:0]  wr_addr,
  output logic [BYTE_W-1:0]          wr_data,
  output logic                       presc_clr
);
  localparam int TW  = $clog2(N_TIME);
  localparam int AIW = (N_ALARM > 1) ? $clog2(N_ALARM) : 1;
  localparam logic [AW-1:0] PTR_TOP = '1;

  logic                                hdr;
  logic                                wmode;
  logic [AW-1:0]                       ptr;
  logic [N_TIME-1:0][BYTE_W-1:0]       shadow;
  logic [N_ALARM-1:0][BYTE_W-1:0]      alarm;

  logic [AW-1:0]     ld_addr;
  logic [AW-1:0]     ld_aoff;
  logic [AW-1:0]     wr_aoff;
  logic              ld_read;
  logic [BYTE_W-1:0] rd_val;

  // Address and data of the byte to be sent next
  always_comb begin
    ld_addr = hdr ? rx_byte[AW-1:0] : ptr + 1'b1;
    ld_read = hdr ? !cmd_is_write(rx_byte) : !wmode;
    ld_aoff = ld_addr - AW'(N_TIME);
    rd_val  = '0;                                    // R9
    if (int'(ld_addr) < N_TIME)
      rd_val = shadow[ld_addr[TW-1:0]] & time_mask(int'(ld_addr));  // R4, R7
    else if (int'(ld_addr) < N_TIME + N_ALARM)
      rd_val = alarm[ld_aoff[AIW-1:0]];              // R8
  end

  assign tx_vld  = rx_done;
  assign tx_data = ld_read ? rd_val : '0;
  assign wr_aoff = ptr - AW'(N_TIME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr       <= 1'b1;
      wmode     <= 1'b0;
      ptr       <= '0;
      shadow    <= '0;
      alarm     <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      presc_clr <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      presc_clr <= 1'b0;
      if (cs_fall) begin
        for (int i = 0; i < N_TIME; i++)
          shadow[i] <= live_time[i*BYTE_W +: BYTE_W];
      end
      if (!cs_act) begin
        hdr <= 1'b1;
      end else if (rx_done) begin
        if (hdr) begin
          ptr   <= rx_byte[AW-1:0];
          wmode <= cmd_is_write(rx_byte);            // R1
          hdr   <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;                         // R3
          if (wmode) begin
            if (int'(ptr) < N_TIME) begin
              wr_en     <= 1'b1;
              wr_addr   <= ptr[TW-1:0];
              wr_data   <= rx_byte & time_mask(int'(ptr));
              presc_clr <= (int'(ptr) < N_CLR);      // R6
            end else if (int'(ptr) < N_TIME + N_ALARM) begin
              alarm[wr_aoff[AIW-1:0]] <= rx_byte;
            end
          end
        end
      end
    end
  end

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  a_r6_clr_with_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |-> wr_en && (int'(wr_addr) < N_CLR));
  a_r7_no_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~time_mask(int'(wr_addr))) == '0));
  a_r4_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cs_fall) |=> $stable(shadow));
  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && rx_done && !hdr && ptr == PTR_TOP) |=> (ptr == '0));
endmodule

// File: rtl/spi_rtc_regif.sv
module spi_rtc_regif
  import spi_rtc_pkg::*;
#(
  parameter int N_TIME  = 8,
  parameter int N_ALARM = 4,
  parameter int N_CLR   = 4,
  parameter int AW      = 4,
  parameter int SYNC    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_csn,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  input  logic [N_TIME*BYTE_W-1:0]   live_time,
  output logic                       cnt_wr_en,
  output logic [$clog2(N_TIME)-1:0]  cnt_wr_addr,
  output logic [BYTE_W-1:0]          cnt_wr_data,
  output logic                       presc_clr
);
  logic              sclk_rise, sclk_fall, cs_act, cs_fall, mosi_s;
  logic              rx_done, tx_vld;
  logic [BYTE_W-1:0] rx_byte, tx_data;

  spi_rtc_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .cs_fall(cs_fall), .mosi_s(mosi_s)
  );

  spi_rtc_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(mosi_s), .tx_vld(tx_vld), .tx_data(tx_data),
    .rx_done(rx_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_rtc_regs #(.N_TIME(N_TIME), .N_ALARM(N_ALARM), .N_CLR(N_CLR), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .rx_done(rx_done), .rx_byte(rx_byte), .live_time(live_time),
    .tx_vld(tx_vld), .tx_data(tx_data), .wr_en(cnt_wr_en),
    .wr_addr(cnt_wr_addr), .wr_data(cnt_wr_data), .presc_clr(presc_clr)
  );
endmodule

// File: tb/sim_spi_rtc_regif.sv
`timescale 1ns/1ps
module sim_spi_rtc_regif;
  localparam time CLK_HALF = 10ns;   // 50 MHz
  localparam time BIT_HALF = 160ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, csn = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [63:0] live;
  logic        wr_en, clr;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0, n_bad = 0, n_wr = 0, n_clr = 0;
  logic [2:0] last_addr;
  logic [7:0] last_data;
  logic       last_clr;
  logic [7:0] rbuf [16];
  bit         done = 0;

  spi_rtc_regif u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .live_time(live), .cnt_wr_en(wr_en), .cnt_wr_addr(wr_addr),
    .cnt_wr_data(wr_data), .presc_clr(clr)
  );

  always #(CLK_HALF) clk = ~clk;

  always @(posedge clk) begin
    if (wr_en) begin
      n_wr++; last_addr = wr_addr; last_data = wr_data; last_clr = clr;
    end
    if (clr) n_clr++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      sclk = 1'b0; mosi = tx[i];
      #(BIT_HALF);
      rx[i] = miso;
      sclk = 1'b1;
      #(BIT_HALF);
    end
  endtask

  // One access: command byte then n data bytes; reads land in rbuf
  task automatic access(input logic [7:0] cmd, input int n, input logic [7:0] wd0, input logic [7:0] wd1);
    logic [7:0] r;
    csn = 1'b0; #(BIT_HALF);
    send_bits(cmd, 8, r);
    chk("R2 miso zero in command", {24'd0, r}, 32'd0);
    for (int k = 0; k < n; k++) begin
      send_bits(k == 0 ? wd0 : wd1, 8, r);
      rbuf[k] = r;
    end
    #(BIT_HALF); csn = 1'b1; #(BIT_HALF * 4);
  endtask

  localparam logic [15:0] RD_VEC [11] = '{
    16'h00FF, 16'h017F, 16'h0259, 16'h0372, 16'h0405, 16'h0531,
    16'h0692, 16'h0724, 16'h0800, 16'h0C00, 16'h0F00 };

  initial begin
    logic [7:0] r;
    live = 64'h24F2F1FDF2D9FFFF;
    #3;
    #(CLK_HALF * 10) rst_n = 1'b1;
    #(CLK_HALF * 10);
    chk("R11 miso after reset", {31'd0, miso}, 0);
    chk("R11 no strobe after reset", n_wr, 0);

    // R4 R7 R9 R11: single-byte reads from the vector table
    foreach (RD_VEC[i]) begin
      access(RD_VEC[i][15:8], 1, 8'h00, 8'h00);
      chk($sformatf("R7 read addr %0h", RD_VEC[i][15:8]), {24'd0, rbuf[0]}, {24'd0, RD_VEC[i][7:0]});
    end

    // R3 burst from 06h crosses into the alarm registers
    access(8'h06, 4, 8'h00, 8'h00);
    chk("R3 burst 06", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h92240000);
    // R3 wrap from 0Fh to 00h
    access(8'h0E, 4, 8'h00, 8'h00);
    chk("R3 wrap 0E", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'h0000FF7F);

    // R4 snapshot: live changes after select, read still returns old instant
    csn = 1'b0; #(BIT_HALF);
    send_bits(8'h00, 8, r);
    live = 64'h0102030405060708;
    for (int k = 0; k < 8; k++) begin send_bits(8'h00, 8, r); rbuf[k] = r; end
    #(BIT_HALF); csn = 1'b1; #(BIT_HALF * 4);
    chk("R4 shadow low", {rbuf[0], rbuf[1], rbuf[2], rbuf[3]}, 32'hFF7F5972);
    chk("R4 shadow high", {rbuf[4], rbuf[5], rbuf[6], rbuf[7]}, 32'h05319224);
    access(8'h00, 1, 8'h00, 8'h00);
    chk("R4 new capture", {24'd0, rbuf[0]}, 32'h08);

    // R1 R5 R6 R7 writes to the counter
    access(8'h81, 1, 8'hFF, 8'h00);
    chk("R5 strobe count", n_wr, 1);
    chk("R7 write 01", {last_addr, last_data}, {3'd1, 8'h7F});
    chk("R6 clr on 01", {31'd0, last_clr}, 1);
    access(8'h86, 1, 8'hFF, 8'h00);
    chk("R7 write 06", {last_addr, last_data}, {3'd6, 8'h9F});
    chk("R6 no clr on 06", n_clr, 1);
    access(8'h84, 1, 8'hFF, 8'h00);
    chk("R7 write 04", {last_addr, last_data}, {3'd4, 8'h07});
    // R3 R9 burst write 0F (ignored) then 00
    access(8'h8F, 2, 8'hAA, 8'h12);
    chk("R9 R3 write wrap count", n_wr, 4);
    chk("R3 write wrap data", {last_addr, last_data}, {3'd0, 8'h12});
    chk("R6 clr on 00", n_clr, 2);

    // R8 alarm registers
    access(8'h88, 2, 8'hAB, 8'hCD);
    chk("R8 no counter strobe", n_wr, 4);
    access(8'h08, 2, 8'h00, 8'h00);
    chk("R8 alarm readback", {rbuf[0], rbuf[1]}, 16'hABCD);

    // R9 writes to empty address ignored
    access(8'h8C, 1, 8'h55, 8'h00);
    access(8'h0B, 2, 8'h00, 8'h00);
    chk("R9 empty reads zero", {rbuf[0], rbuf[1]}, 16'h0000);
    chk("R9 no strobe", n_wr, 4);

    // R10 abort: partial data byte to 0Ah
    csn = 1'b0; #(BIT_HALF);
    send_bits(8'h8A, 8, r);
    send_bits(8'hFF, 4, r);
    #(BIT_HALF); csn = 1'b1; #(BIT_HALF * 4);
    access(8'h0A, 1, 8'h00, 8'h00);
    chk("R10 aborted byte dropped", {24'd0, rbuf[0]}, 0);
    // R10 abort mid command byte, then a clean access
    csn = 1'b0; #(BIT_HALF);
    send_bits(8'h88, 3, r);
    #(BIT_HALF); csn = 1'b1; #(BIT_HALF * 4);
    access(8'h08, 1, 8'h00, 8'h00);
    chk("R10 fresh command after abort", {24'd0, rbuf[0]}, 32'hAB);
    chk("R10 no stray strobe", n_wr, 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule